// File: doc/BRIEF.md
# Scan-Friendly Lookahead ALU

This block is an 8-bit arithmetic/logic unit. It works on two operands and a carry-in. The logical result and the arithmetic sum are formed side by side, and a single select line picks which of the two reaches the registered output. The adder is built as a carry-lookahead tree:

- a per-bit generate/propagate cell for each operand bit;
- a two-level convergent tree of group combiners;
- carry cells that deliver one lookahead carry into each of four 2-bit ripple segments.

One extra input, the test strobe, changes two things. The per-bit cells become plain pass-throughs, so generate takes the bit of A and propagate takes the bit of B. The carry cells are defined so that a group pair with generate and propagate both at one also has an observable effect. This lets every cell of the lookahead network be driven with all of its input patterns. With the strobe low, the adder behaves exactly as an ordinary lookahead adder.

The result and the carry flag are registered, so each operation appears one clock after its inputs.

Top module: `lookahead_alu`

## Requirements
- R1: While rst_n is low, and on the first edge after it falls, res_q and cout_q are 0.
- R2: res_q and cout_q show the operation of the inputs sampled at the previous rising clock edge.
- R3: With mode_arith=0, res_q is the bitwise function of op_a and op_b chosen by lop_sel: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR. This holds whatever the value of test_z.
- R4: With mode_arith=0, cout_q is 0. With mode_arith=1, res_q is the sum path and cout_q is the carry out of bit 7.
- R5: With mode_arith=1 and test_z=0, {cout_q,res_q} equals op_a + op_b + cin.
- R6: With test_z=1, each bit cell yields generate = op_a[i] and propagate = op_b[i]. With test_z=0 it yields generate = a&b and propagate = a^b.
- R7: A carry cell outputs (G & ~P) | (P & carry_in) from its group pair. The segment carries are as follows:
  - bit 2 from group 1:0 and cin;
  - bit 4 from group 3:0 and cin;
  - bit 6 from group 5:4 and the bit-4 carry;
  - the carry out from group 7:4 and the bit-4 carry.
- R8: A group combiner forms G = Ghi | (Phi & Glo) and P = Phi & Plo. Within each 2-bit segment the sum bits use op_a^op_b and ripple the carry as a full adder.
- R9: With test_z=0, no group pair in the tree ever has G=1 and P=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| cin | input | 1 | Carry into bit 0 |
| lop_sel | input | 2 | Logic operation code |
| mode_arith | input | 1 | 1 selects the sum, 0 selects the logic result |
| test_z | input | 1 | Test strobe for the lookahead network |
| res_q | output | 8 | Registered result |
| cout_q | output | 1 | Registered carry out (0 in logic mode) |

## Verification
The assertions assume that the inputs are settled at each rising edge. The check that group pairs never reach (1,1), and the check that the sum equals plain addition, are armed only while test_z is low; test-mode vectors are free to produce any pattern. The bench changes inputs only on falling edges and holds test_z steady across each operation. Test-mode vectors are chosen with all-ones and all-zeros operands, so that the pair (1,1) and pure kill or generate patterns all reach the carry cells.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int ALU_W = 8;
    localparam int SEG_W = 2;
    localparam int NSEG  = ALU_W / SEG_W;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOR = 2'b11
    } lop_e;

    typedef struct packed {
        logic [ALU_W-1:0] res;
        logic             cy;
    } alu_out_t;
endpackage

// File: rtl/alu_bit_gp.sv
module alu_bit_gp
    import alu_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic tz,
    output gp_t  gp
);
    always_comb begin
        gp.g = (~tz & a & b) | (tz & a);
        gp.p = (~tz & (a ^ b)) | (tz & b);
    end
endmodule

// File: rtl/alu_grp_merge.sv
module alu_grp_merge
    import alu_pkg::*;
(
    input  gp_t hi,
    input  gp_t lo,
    output gp_t grp
);
    always_comb begin
        grp.g = hi.g | (hi.p & lo.g);
        grp.p = hi.p & lo.p;
    end
endmodule

// File: rtl/alu_carry_cell.sv
module alu_carry_cell
    import alu_pkg::*;
(
    input  gp_t  grp,
    input  logic c_in,
    output logic c_out
);
    always_comb c_out = (grp.g & ~grp.p) | (grp.p & c_in);
endmodule

// File: rtl/alu_ripple_seg.sv
module alu_ripple_seg #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    output logic [W-1:0] s
);
    logic [W-1:0] c;
    assign c[0] = c_in;
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i] = a[i] ^ b[i] ^ c[i];
        if (i < W - 1) begin : g_chain
            assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
        end
    end
endmodule

// File: rtl/lookahead_alu.sv
module lookahead_alu
    import alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ALU_W-1:0] op_a,
    input  logic [ALU_W-1:0] op_b,
    input  logic             cin,
    input  logic [1:0]       lop_sel,
    input  logic             mode_arith,
    input  logic             test_z,
    output logic [ALU_W-1:0] res_q,
    output logic             cout_q
);
    gp_t              bit_gp [ALU_W];
    gp_t              lvl1   [NSEG];
    gp_t              lvl2   [NSEG/2];
    logic [NSEG-1:0]  seg_c;
    logic             c_top;
    logic [ALU_W-1:0] sum;
    logic [ALU_W-1:0] lres;
    alu_out_t         out_d, out_q;

    for (genvar i = 0; i < ALU_W; i++) begin : g_gp
        alu_bit_gp u_gp (.a(op_a[i]), .b(op_b[i]), .tz(test_z), .gp(bit_gp[i]));
    end

    for (genvar k = 0; k < NSEG; k++) begin : g_l1
        alu_grp_merge u_m (.hi(bit_gp[2*k+1]), .lo(bit_gp[2*k]), .grp(lvl1[k]));
    end

    for (genvar k = 0; k < NSEG/2; k++) begin : g_l2
        alu_grp_merge u_m (.hi(lvl1[2*k+1]), .lo(lvl1[2*k]), .grp(lvl2[k]));
    end

    assign seg_c[0] = cin;
    alu_carry_cell u_c2 (.grp(lvl1[0]), .c_in(cin),      .c_out(seg_c[1]));
    alu_carry_cell u_c4 (.grp(lvl2[0]), .c_in(cin),      .c_out(seg_c[2]));
    alu_carry_cell u_c6 (.grp(lvl1[2]), .c_in(seg_c[2]), .c_out(seg_c[3]));
    alu_carry_cell u_c8 (.grp(lvl2[1]), .c_in(seg_c[2]), .c_out(c_top));

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        alu_ripple_seg #(.W(SEG_W)) u_seg (
            .a   (op_a[k*SEG_W +: SEG_W]),
            .b   (op_b[k*SEG_W +: SEG_W]),
            .c_in(seg_c[k]),
            .s   (sum[k*SEG_W +: SEG_W])
        );
    end

    always_comb begin
        unique case (lop_e'(lop_sel))
            LOP_AND: lres = op_a & op_b;
            LOP_OR:  lres = op_a | op_b;
            LOP_XOR: lres = op_a ^ op_b;
            default: lres = ~(op_a | op_b);
        endcase
        out_d.res = mode_arith ? sum : lres;
        out_d.cy  = mode_arith & c_top;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_q  = out_q.res;
    assign cout_q = out_q.cy;

    logic gp11_any;
    always_comb begin
        gp11_any = 1'b0;
        for (int k = 0; k < NSEG; k++)   gp11_any |= lvl1[k].g & lvl1[k].p;
        for (int k = 0; k < NSEG/2; k++) gp11_any |= lvl2[k].g & lvl2[k].p;
    end

    AST_NO_GP11: assert property (@(posedge clk) disable iff (!rst_n)
        !test_z |-> !gp11_any); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (res_q == '0 && !cout_q)); // R1
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_arith |=> !cout_q); // R4
    AST_ADD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_arith && !test_z) |=>
        ({cout_q, res_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + {8'd0, $past(cin)}))); // R5
    AST_AND_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_arith && lop_sel == 2'b00) |=> res_q == ($past(op_a) & $past(op_b))); // R3
endmodule

// File: tb/tb_lookahead_alu.sv
module tb_lookahead_alu;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] op_a, op_b;
    logic       cin;
    logic [1:0] lop_sel;
    logic       mode_arith, test_z;
    logic [7:0] res_q;
    logic       cout_q;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lookahead_alu dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .cin(cin),
        .lop_sel(lop_sel), .mode_arith(mode_arith), .test_z(test_z),
        .res_q(res_q), .cout_q(cout_q)
    );

    // {arith, test, lop[1:0], cin, a[7:0], b[7:0], exp_c, exp_r[7:0]}
    localparam int NVEC = 12;
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b1,1'b0,2'd0,1'b0,8'h12,8'h34,1'b0,8'h46},  // R5
        {1'b1,1'b0,2'd0,1'b1,8'hFF,8'h00,1'b1,8'h00},  // R5 full ripple
        {1'b1,1'b0,2'd0,1'b0,8'hFF,8'hFF,1'b1,8'hFE},  // R5
        {1'b0,1'b0,2'd0,1'b0,8'hF0,8'h3C,1'b0,8'h30},  // R3 AND
        {1'b0,1'b0,2'd1,1'b0,8'hF0,8'h3C,1'b0,8'hFC},  // R3 OR
        {1'b0,1'b0,2'd2,1'b0,8'hF0,8'h3C,1'b0,8'hCC},  // R3 XOR
        {1'b0,1'b0,2'd3,1'b1,8'hF0,8'h3C,1'b0,8'h03},  // R3 NOR, R4
        {1'b1,1'b1,2'd0,1'b0,8'hFF,8'hFF,1'b0,8'hAA},  // R7 gp=11 kills
        {1'b1,1'b1,2'd0,1'b1,8'hFF,8'hFF,1'b1,8'hFF},  // R7 gp=11 passes cin
        {1'b1,1'b1,2'd0,1'b0,8'hFF,8'h00,1'b1,8'h03},  // R6 gp=10 generates
        {1'b1,1'b1,2'd0,1'b0,8'h00,8'hFF,1'b0,8'hFF},  // R6 gp=01 passes
        {1'b0,1'b1,2'd2,1'b1,8'hF0,8'h3C,1'b0,8'hCC}   // R3 test_z ignored
    };

    function automatic logic [8:0] test_model(input logic [7:0] a, input logic [7:0] b, input logic ci);
        logic [3:0] g1, p1;
        logic [1:0] g2, p2;
        logic [3:0] sc;
        logic       c8, c;
        logic [7:0] s;
        for (int k = 0; k < 4; k++) begin
            g1[k] = a[2*k+1] | (b[2*k+1] & a[2*k]);
            p1[k] = b[2*k+1] & b[2*k];
        end
        for (int k = 0; k < 2; k++) begin
            g2[k] = g1[2*k+1] | (p1[2*k+1] & g1[2*k]);
            p2[k] = p1[2*k+1] & p1[2*k];
        end
        sc[0] = ci;
        sc[1] = (g1[0] & ~p1[0]) | (p1[0] & ci);
        sc[2] = (g2[0] & ~p2[0]) | (p2[0] & ci);
        sc[3] = (g1[2] & ~p1[2]) | (p1[2] & sc[2]);
        c8    = (g2[1] & ~p2[1]) | (p2[1] & sc[2]);
        for (int k = 0; k < 4; k++) begin
            c = sc[k];
            for (int j = 0; j < 2; j++) begin
                s[2*k+j] = a[2*k+j] ^ b[2*k+j] ^ c;
                c = (a[2*k+j] & b[2*k+j]) | (c & (a[2*k+j] ^ b[2*k+j]));
            end
        end
        return {c8, s};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic ar, input logic tz, input logic [1:0] q, input logic ci,
                          input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        mode_arith = ar; test_z = tz; lop_sel = q; cin = ci; op_a = a; op_b = b;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; op_a = 8'hA5; op_b = 8'h5A; cin = 1'b1;
        lop_sel = 2'd1; mode_arith = 1'b1; test_z = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {cout_q, res_q}, 9'h000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_op(VEC[i][29], VEC[i][28], VEC[i][27:26], VEC[i][25], VEC[i][24:17], VEC[i][16:9]);
            check(VEC[i][29] ? (VEC[i][28] ? "R7" : "R5") : "R3", {cout_q, res_q}, VEC[i][8:0]);
        end

        // R2: one-cycle latency, back-to-back operations
        @(negedge clk);
        mode_arith = 1'b1; test_z = 1'b0; cin = 1'b0; op_a = 8'h01; op_b = 8'h01;
        @(negedge clk);
        op_a = 8'h80; op_b = 8'h80;
        check("R2", {cout_q, res_q}, 9'h002);
        @(negedge clk);
        check("R2", {cout_q, res_q}, 9'h100);

        // R5 / R6 / R8: sweep with an LFSR in both modes
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 200; i++) begin
                logic [8:0] exp;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                run_op(1'b1, i[0], 2'd0, lf[3], lf[15:8], lf[7:0] ^ lf[11:4]);
                if (i[0]) exp = test_model(op_a, op_b, cin);
                else      exp = {1'b0, op_a} + {1'b0, op_b} + {8'd0, cin};
                check(i[0] ? "R6/R8" : "R5", {cout_q, res_q}, exp);
            end
        end

        // R4: logic mode clears carry even when the sum would carry
        run_op(1'b0, 1'b0, 2'd1, 1'b1, 8'hFF, 8'hFF);
        check("R4", {cout_q, res_q}, 9'h0FF);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1", {cout_q, res_q}, 9'h000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule